// File: doc/BRIEF.md
# Periodic Trigger Output Unit

The block produces a pulse train on one of several general-purpose output pins, timed against an external precision clock that reaches it as a seconds/nanoseconds time bus. Once armed, it waits for an absolute start time. At that time and at every later multiple of the cycle width it asserts the chosen pin for a programmed pulse width, and it deasserts the pin for the remainder of each cycle. The train runs without end when the cycle count is zero. Otherwise it stops after the programmed number of cycles and reports completion through a done flag and, when the notify option is set, an interrupt flag.

Configuration sits on plain input ports and is captured when the arm strobe is seen. The fields are the start time, the cycle width in nanoseconds, the cycle count, the pulse width in 8 ns units, the polarity pattern, the output index and the notify option. A stop strobe halts the unit and leaves every pin at its present level. An arm with an unusable configuration, or with a start time already in the past, raises an error flag and does not start. Done and interrupt are cleared by write-one strobes.

Top module: `ptou_unit`

## Requirements
- R1: An arm strobe with a valid configuration and a start time not earlier than the current time sets active on the next clock edge and drives the selected pin to its idle level until the start time is reached.
- R2: With pattern 0, each cycle starts at start time plus k times the cycle width. At the first clock whose time bus value has reached that instant, the selected pin goes to 1. It returns to 0 at the first clock whose time has reached the cycle start plus pulse_units times 8 ns.
- R3: A cycle count of 0 repeats the train indefinitely. A count N > 0 gives N pulses. At the first clock whose time reaches start + N × cycle width, done is set, active clears and the pin returns to its idle level.
- R4: The interrupt flag is set together with done only if notify was 1 when the unit was armed.
- R5: An arm raises error, leaves active at 0 and changes no pin if any of these holds: the start time is strictly earlier than the current time, the cycle width is 0 or at least 1,000,000,000, or the output index is at least NUM_OUT.
- R6: The stop strobe clears active and error on the next edge and leaves every pin at its present level, including in the middle of a pulse.
- R7: clr_done clears done and clr_irq clears irq. A set in the same cycle as its clear wins, so the flag reads 1 for that one cycle.
- R8: With pattern 1 the polarity is inverted: the idle level is 1 and the pulse drives the pin to 0.
- R9: When the pulse width is at least the cycle width, the pin stays asserted across cycle boundaries. A new cycle start takes priority over the end of the previous pulse.
- R10: Start, edge and pulse-end times that cross a seconds boundary carry correctly from the nanoseconds field into the seconds field.
- R11: Pins other than the selected one never change while the unit runs.
- R12: After reset all pins, active, done, error and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_sec | input | 32 | Current time, seconds |
| now_ns | input | 30 | Current time, nanoseconds (0..999,999,999) |
| cfg_start_sec | input | 32 | Start time, seconds |
| cfg_start_ns | input | 30 | Start time, nanoseconds |
| cfg_cycle_ns | input | CYC_W | Cycle width in ns |
| cfg_count | input | CNT_W | Number of cycles, 0 = endless |
| cfg_pulse_units | input | PW_W | Pulse width in 8 ns units |
| cfg_pattern | input | 1 | 0 = active-high pulse, 1 = active-low pulse |
| cfg_pin | input | SEL_W | Index of the driven output |
| cfg_notify | input | 1 | Raise irq when a finite train completes |
| ctl_stop | input | 1 | Stop strobe: halt, clear error, hold pins |
| ctl_arm | input | 1 | Arm strobe: capture configuration and start |
| clr_done | input | 1 | Write-one clear of done |
| clr_irq | input | 1 | Write-one clear of irq |
| trig_out | output | NUM_OUT | Output pins |
| sts_active | output | 1 | Train armed or running |
| sts_done | output | 1 | Finite train completed |
| sts_error | output | 1 | Arm rejected |
| sts_irq | output | 1 | Completion interrupt |

## Verification
Two kinds of event can land on the same edge. The first is the end of one pulse and the start of the next cycle, when the pulse width reaches or exceeds the cycle width. The second is completion setting done and irq while software clears them. The first is provoked by random and directed cases whose pulse width is at least the cycle width; the pin must stay asserted through every boundary. The second is provoked by a directed run that holds both clear strobes high throughout. Done and irq must read 1 for exactly the cycle whose time first reaches the end of the last cycle, and 0 in every other cycle.

// File: rtl/ptou_pkg.sv
package ptou_pkg;
   localparam int NS_W = 30;
   localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1000000000;

   typedef struct packed {
      logic [31:0]     sec;
      logic [NS_W-1:0] ns;
   } ptime_t;

   // add a sub-second interval with carry into seconds
   function automatic ptime_t ptime_add(ptime_t t, logic [NS_W-1:0] d);
      ptime_t r;
      logic [NS_W:0] s;
      s = {1'b0, t.ns} + {1'b0, d};
      if (s >= {1'b0, NS_PER_SEC}) begin
         r.sec = t.sec + 32'd1;
         r.ns  = NS_W'(s - {1'b0, NS_PER_SEC});
      end else begin
         r.sec = t.sec;
         r.ns  = NS_W'(s);
      end
      return r;
   endfunction

   function automatic logic ptime_ge(ptime_t a, ptime_t b);
      return (a.sec > b.sec) || ((a.sec == b.sec) && (a.ns >= b.ns));
   endfunction
endpackage

// File: rtl/ptou_sched.sv
module ptou_sched
   import ptou_pkg::*;
#(
   parameter int NUM_OUT = 3,
   parameter int CYC_W   = 30,
   parameter int CNT_W   = 16,
   parameter int PW_W    = 24,
   parameter int SEL_W   = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  ptime_t           now,
   input  ptime_t           cfg_start,
   input  logic [CYC_W-1:0] cfg_cycle_ns,
   input  logic [CNT_W-1:0] cfg_count,
   input  logic [PW_W-1:0]  cfg_pulse_units,
   input  logic             cfg_pattern,
   input  logic [SEL_W-1:0] cfg_pin,
   input  logic             cfg_notify,
   input  logic             ctl_stop,
   input  logic             ctl_arm,
   output logic             active,
   output logic             notify_q,
   output logic             pin_wr,
   output logic [SEL_W-1:0] pin_idx,
   output logic             pin_val,
   output logic             finish,
   output logic             arm_fail
);
   localparam int PNS_W = PW_W + 3;

   logic             active_q, in_pulse_q, pattern_q;
   ptime_t           next_edge_q, pulse_end_q;
   logic [CYC_W-1:0] cycle_q;
   logic [CNT_W-1:0] count_q, done_cnt_q;
   logic [PW_W-1:0]  pw_q;
   logic [SEL_W-1:0] sel_q;

   logic cfg_ok, start_ok, arm_ok, edge_hit, end_hit, last_cycle;
   logic [NS_W-1:0] cycle_ns_ext, pulse_ns_ext;

   assign cycle_ns_ext = NS_W'(cycle_q);
   assign pulse_ns_ext = NS_W'({pw_q, 3'b000});

   assign cfg_ok   = (cfg_cycle_ns != '0)
                   && (32'(cfg_cycle_ns) < 32'(NS_PER_SEC))
                   && (32'(cfg_pin) < 32'(NUM_OUT))
                   && (cfg_start.ns < NS_PER_SEC);
   assign start_ok = ptime_ge(cfg_start, now);
   assign arm_ok   = cfg_ok && start_ok;

   assign edge_hit   = active_q && ptime_ge(now, next_edge_q);
   assign end_hit    = active_q && in_pulse_q && ptime_ge(now, pulse_end_q);
   assign last_cycle = (count_q != '0) && (done_cnt_q == count_q);

   always_comb begin
      pin_wr   = 1'b0;
      pin_val  = 1'b0;
      pin_idx  = sel_q;
      finish   = 1'b0;
      arm_fail = 1'b0;
      if (ctl_stop) begin
         pin_wr = 1'b0;
      end else if (ctl_arm) begin
         pin_idx = cfg_pin;
         if (arm_ok) begin
            pin_wr  = 1'b1;
            pin_val = cfg_pattern;        // idle level
         end else begin
            arm_fail = 1'b1;
         end
      end else if (edge_hit) begin
         pin_wr  = 1'b1;
         pin_val = last_cycle ? pattern_q : ~pattern_q;
         finish  = last_cycle;
      end else if (end_hit) begin
         pin_wr  = 1'b1;
         pin_val = pattern_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q    <= 1'b0;
         in_pulse_q  <= 1'b0;
         pattern_q   <= 1'b0;
         notify_q    <= 1'b0;
         next_edge_q <= '0;
         pulse_end_q <= '0;
         cycle_q     <= '0;
         count_q     <= '0;
         done_cnt_q  <= '0;
         pw_q        <= '0;
         sel_q       <= '0;
      end else if (ctl_stop) begin
         active_q   <= 1'b0;
         in_pulse_q <= 1'b0;
      end else if (ctl_arm) begin
         active_q    <= arm_ok;
         in_pulse_q  <= 1'b0;
         if (arm_ok) begin
            pattern_q   <= cfg_pattern;
            notify_q    <= cfg_notify;
            next_edge_q <= cfg_start;
            cycle_q     <= cfg_cycle_ns;
            count_q     <= cfg_count;
            done_cnt_q  <= '0;
            pw_q        <= cfg_pulse_units;
            sel_q       <= cfg_pin;
         end
      end else if (edge_hit) begin
         if (last_cycle) begin
            active_q   <= 1'b0;
            in_pulse_q <= 1'b0;
         end else begin
            in_pulse_q  <= 1'b1;
            pulse_end_q <= ptime_add(next_edge_q, pulse_ns_ext);
            next_edge_q <= ptime_add(next_edge_q, cycle_ns_ext);
            done_cnt_q  <= done_cnt_q + 1'b1;
         end
      end else if (end_hit) begin
         in_pulse_q <= 1'b0;
      end
   end

   assign active = active_q;

   AST_PAST_START_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_arm && !ctl_stop && !start_ok) |=> !active_q); // R5
   AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_stop |=> !active_q); // R6
   AST_FINISH_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> (!active_q && !in_pulse_q)); // R3
   AST_EDGE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit && !ctl_stop && !ctl_arm && !last_cycle) |=> in_pulse_q && ptime_ge(next_edge_q, $past(now))); // R2
endmodule

// File: rtl/ptou_status.sv
module ptou_status (
   input  logic clk,
   input  logic rst_n,
   input  logic finish,
   input  logic notify,
   input  logic arm_fail,
   input  logic ctl_stop,
   input  logic clr_done,
   input  logic clr_irq,
   output logic done,
   output logic irq,
   output logic error
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done  <= 1'b0;
         irq   <= 1'b0;
         error <= 1'b0;
      end else begin
         if (finish)        done <= 1'b1;
         else if (clr_done) done <= 1'b0;
         if (finish && notify) irq <= 1'b1;
         else if (clr_irq)     irq <= 1'b0;
         if (ctl_stop)      error <= 1'b0;
         else if (arm_fail) error <= 1'b1;
      end
   end

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> done); // R7
   AST_IRQ_NEEDS_NOTIFY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(finish && notify)); // R4
   AST_ERROR_FROM_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error) |-> $past(arm_fail)); // R5
endmodule

// File: rtl/ptou_pins.sv
module ptou_pins #(
   parameter int NUM_OUT = 3,
   parameter int SEL_W   = 2
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [SEL_W-1:0]   idx,
   input  logic               val,
   output logic [NUM_OUT-1:0] pins
);
   for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           pins[i] <= 1'b0;
         else if (wr && (idx == SEL_W'(i)))    pins[i] <= val;
      end
   end

   AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(pins)); // R11
endmodule

// File: rtl/ptou_unit.sv
module ptou_unit
   import ptou_pkg::*;
#(
   parameter int NUM_OUT = 3,
   parameter int CYC_W   = 30,
   parameter int CNT_W   = 16,
   parameter int PW_W    = 24,
   parameter int SEL_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [31:0]        now_sec,
   input  logic [29:0]        now_ns,
   input  logic [31:0]        cfg_start_sec,
   input  logic [29:0]        cfg_start_ns,
   input  logic [CYC_W-1:0]   cfg_cycle_ns,
   input  logic [CNT_W-1:0]   cfg_count,
   input  logic [PW_W-1:0]    cfg_pulse_units,
   input  logic               cfg_pattern,
   input  logic [SEL_W-1:0]   cfg_pin,
   input  logic               cfg_notify,
   input  logic               ctl_stop,
   input  logic               ctl_arm,
   input  logic               clr_done,
   input  logic               clr_irq,
   output logic [NUM_OUT-1:0] trig_out,
   output logic               sts_active,
   output logic               sts_done,
   output logic               sts_error,
   output logic               sts_irq
);
   if (NUM_OUT < 1)          begin : g_bad_out  $error("NUM_OUT must be positive"); end
   if (CYC_W > NS_W)         begin : g_bad_cyc  $error("CYC_W too wide for ns field"); end
   if (PW_W + 3 > NS_W)      begin : g_bad_pw   $error("PW_W too wide for ns field"); end
   if (CNT_W < 1)            begin : g_bad_cnt  $error("CNT_W must be positive"); end
   if ((1 << SEL_W) < NUM_OUT) begin : g_bad_sel $error("SEL_W too narrow"); end

   ptime_t now_t, start_t;
   logic notify_q, pin_wr, pin_val, finish, arm_fail;
   logic [SEL_W-1:0] pin_idx;

   assign now_t   = '{sec: now_sec, ns: now_ns};
   assign start_t = '{sec: cfg_start_sec, ns: cfg_start_ns};

   ptou_sched #(.NUM_OUT(NUM_OUT), .CYC_W(CYC_W), .CNT_W(CNT_W),
                .PW_W(PW_W), .SEL_W(SEL_W)) u_sched (
      .clk(clk), .rst_n(rst_n), .now(now_t), .cfg_start(start_t),
      .cfg_cycle_ns(cfg_cycle_ns), .cfg_count(cfg_count),
      .cfg_pulse_units(cfg_pulse_units), .cfg_pattern(cfg_pattern),
      .cfg_pin(cfg_pin), .cfg_notify(cfg_notify),
      .ctl_stop(ctl_stop), .ctl_arm(ctl_arm),
      .active(sts_active), .notify_q(notify_q), .pin_wr(pin_wr),
      .pin_idx(pin_idx), .pin_val(pin_val), .finish(finish), .arm_fail(arm_fail));

   ptou_status u_status (
      .clk(clk), .rst_n(rst_n), .finish(finish), .notify(notify_q),
      .arm_fail(arm_fail), .ctl_stop(ctl_stop), .clr_done(clr_done),
      .clr_irq(clr_irq), .done(sts_done), .irq(sts_irq), .error(sts_error));

   ptou_pins #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_pins (
      .clk(clk), .rst_n(rst_n), .wr(pin_wr), .idx(pin_idx), .val(pin_val),
      .pins(trig_out));

   AST_STOP_HOLDS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_stop |=> $stable(trig_out)); // R6
   AST_FAIL_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_error) |-> !sts_active); // R5
endmodule

// File: tb/tb_ptou_unit.sv
module tb_ptou_unit;
   localparam int NUM_OUT = 3;
   localparam int CYC_W = 30, CNT_W = 16, PW_W = 24, SEL_W = 2;
   localparam longint NSEC = 64'd1000000000;
   localparam longint STEP = 40;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [31:0] now_sec = '0, cfg_start_sec = '0;
   logic [29:0] now_ns = '0, cfg_start_ns = '0;
   logic [CYC_W-1:0] cfg_cycle_ns = '0;
   logic [CNT_W-1:0] cfg_count = '0;
   logic [PW_W-1:0]  cfg_pulse_units = '0;
   logic cfg_pattern = 1'b0, cfg_notify = 1'b0;
   logic [SEL_W-1:0] cfg_pin = '0;
   logic ctl_stop = 1'b0, ctl_arm = 1'b0, clr_done = 1'b0, clr_irq = 1'b0;
   logic [NUM_OUT-1:0] trig_out;
   logic sts_active, sts_done, sts_error, sts_irq;

   int total = 0, bad = 0;
   longint tcur;
   logic [NUM_OUT-1:0] pin_exp = '0;

   always #10 clk = ~clk;   // 50 MHz

   ptou_unit #(.NUM_OUT(NUM_OUT), .CYC_W(CYC_W), .CNT_W(CNT_W), .PW_W(PW_W), .SEL_W(SEL_W)) dut (
      .clk(clk), .rst_n(rst_n), .now_sec(now_sec), .now_ns(now_ns),
      .cfg_start_sec(cfg_start_sec), .cfg_start_ns(cfg_start_ns),
      .cfg_cycle_ns(cfg_cycle_ns), .cfg_count(cfg_count),
      .cfg_pulse_units(cfg_pulse_units), .cfg_pattern(cfg_pattern),
      .cfg_pin(cfg_pin), .cfg_notify(cfg_notify), .ctl_stop(ctl_stop),
      .ctl_arm(ctl_arm), .clr_done(clr_done), .clr_irq(clr_irq),
      .trig_out(trig_out), .sts_active(sts_active), .sts_done(sts_done),
      .sts_error(sts_error), .sts_irq(sts_irq));

   task automatic check(string rq, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at t=%0d", rq, act, exp, tcur);
      end
   endtask

   task automatic drive_time();
      now_sec = 32'(tcur / NSEC);
      now_ns  = 30'(tcur % NSEC);
   endtask

   function automatic logic mdl_lvl(longint t, longint s, longint c, longint p, longint n, logic pat);
      longint k;
      if (t < s) return pat;
      k = (t - s) / c;
      if (n != 0 && k >= n) return pat;
      return (t - s - k * c < p) ? ~pat : pat;
   endfunction

   function automatic logic mdl_fin(longint t, longint s, longint c, longint n);
      return (n != 0) && (t >= s + n * c);
   endfunction

   // arm, run ncyc clocks with checks, then stop and clear
   task automatic run_case(string tag, longint off, longint c, longint pw, longint n,
                           int pin, logic pat, logic ntf, int ncyc, logic hold_clr);
      longint s, p;
      logic lvl;
      logic [NUM_OUT-1:0] vexp;
      s = tcur + off;
      p = pw * 8;
      lvl = pat;
      @(negedge clk);
      cfg_start_sec = 32'(s / NSEC);
      cfg_start_ns  = 30'(s % NSEC);
      cfg_cycle_ns  = CYC_W'(c);
      cfg_count     = CNT_W'(n);
      cfg_pulse_units = PW_W'(pw);
      cfg_pattern   = pat;
      cfg_pin       = SEL_W'(pin);
      cfg_notify    = ntf;
      ctl_arm       = 1'b1;
      clr_done      = hold_clr;
      clr_irq       = hold_clr;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         ctl_arm = 1'b0;
         lvl = mdl_lvl(tcur, s, c, p, n, pat);
         vexp = pin_exp;
         vexp[pin] = lvl;
         check(tag, trig_out, vexp);                              // R2/R8/R9/R10 + R11
         check("R1_R3 active", sts_active, !mdl_fin(tcur, s, c, n));
         if (hold_clr) begin
            check("R7 done same-cycle", sts_done,
                  mdl_fin(tcur, s, c, n) && !mdl_fin(tcur - STEP, s, c, n));
            check("R7 irq same-cycle", sts_irq,
                  ntf && mdl_fin(tcur, s, c, n) && !mdl_fin(tcur - STEP, s, c, n));
         end else begin
            check("R3 done", sts_done, mdl_fin(tcur, s, c, n));
            check("R4 irq", sts_irq, ntf && mdl_fin(tcur, s, c, n));
         end
         tcur += STEP;
         drive_time();
      end
      pin_exp[pin] = lvl;
      ctl_stop = 1'b1;
      clr_done = 1'b0;
      clr_irq  = 1'b0;
      @(negedge clk);
      ctl_stop = 1'b0;
      check("R6 stop active", sts_active, 0);
      check("R6 stop holds pins", trig_out, pin_exp);
      clr_done = 1'b1;
      clr_irq  = 1'b1;
      @(negedge clk);
      clr_done = 1'b0;
      clr_irq  = 1'b0;
      check("R7 done clear", sts_done, 0);
      check("R7 irq clear", sts_irq, 0);
   endtask

   task automatic arm_bad(string tag, longint off, longint c, int pin);
      longint s;
      s = tcur + off;
      @(negedge clk);
      cfg_start_sec = 32'(s / NSEC);
      cfg_start_ns  = 30'(s % NSEC);
      cfg_cycle_ns  = CYC_W'(c);
      cfg_count     = CNT_W'(2);
      cfg_pulse_units = PW_W'(10);
      cfg_pattern   = ~pin_exp[0];
      cfg_pin       = SEL_W'(pin);
      ctl_arm       = 1'b1;
      @(negedge clk);
      ctl_arm = 1'b0;
      check({tag, " error"}, sts_error, 1);
      check({tag, " inactive"}, sts_active, 0);
      check({tag, " pins"}, trig_out, pin_exp);
      ctl_stop = 1'b1;
      @(negedge clk);
      ctl_stop = 1'b0;
      check("R6 stop clears error", sts_error, 0);
   endtask

   initial begin
      #(200000 * 20);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      tcur = 5 * NSEC + 1000;
      drive_time();
      repeat (3) @(negedge clk);
      check("R12 reset pins", trig_out, 0);
      check("R12 reset flags", {sts_active, sts_done, sts_error, sts_irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed
      run_case("R2 positive", 200, 400, 20, 3, 0, 1'b0, 1'b1, 45, 1'b0);
      run_case("R2 endless", 120, 200, 6, 0, 1, 1'b0, 1'b0, 40, 1'b0);
      run_case("R8 inverted", 160, 320, 15, 2, 2, 1'b1, 1'b1, 25, 1'b0);
      run_case("R9 overlap", 80, 200, 40, 3, 0, 1'b0, 1'b1, 22, 1'b0);
      run_case("R4 no-notify", 80, 160, 8, 2, 1, 1'b0, 1'b0, 15, 1'b0);
      run_case("R6 mid-pulse", 80, 800, 60, 0, 1, 1'b0, 1'b0, 6, 1'b0);
      run_case("R7 clear race", 120, 240, 10, 2, 2, 1'b0, 1'b1, 20, 1'b1);
      tcur = 7 * NSEC - 300;
      drive_time();
      run_case("R10 sec carry", 200, 120, 7, 4, 0, 1'b0, 1'b1, 25, 1'b0);
      arm_bad("R5 past start", -40, 400, 0);
      arm_bad("R5 zero cycle", 400, 0, 1);
      arm_bad("R5 long cycle", 400, 1000000000, 1);
      arm_bad("R5 bad pin", 400, 400, 3);

      // constrained random
      for (int r = 0; r < 12; r++) begin
         longint c, pw, n, off;
         int pin, ncyc;
         logic pat, ntf;
         c   = 40 + longint'($urandom_range(0, 760));
         pw  = 5 + longint'($urandom_range(0, 110));
         n   = longint'($urandom_range(0, 4));
         off = 80 + longint'($urandom_range(0, 320));
         pin = int'($urandom_range(0, NUM_OUT - 1));
         pat = 1'($urandom_range(0, 1));
         ntf = 1'($urandom_range(0, 1));
         ncyc = (n == 0) ? 50 : int'((off + n * c) / STEP) + 6;
         if ((r % 4) == 3) begin
            tcur = (tcur / NSEC + 1) * NSEC - longint'($urandom_range(100, 600));
            drive_time();
         end
         run_case(pw * 8 >= c ? "R9 random" : (pat ? "R8 random" : "R2 random"),
                  off, c, pw, n, pin, pat, ntf, ncyc, 1'b0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule